// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Condition Flags

This block is a purely combinational datapath slice that takes a 3-bit operation select, two 8-bit operands and the current condition-flag byte. From these it forms an 8-bit result and a new flag byte. It covers the eight basic accumulator operations. Four of them are arithmetic: plain add, add with carry, plain subtract and subtract with borrow. Three are logical: AND, exclusive OR and inclusive OR. The last is a compare, which computes a difference to set the flags but passes the first operand through unchanged as the result.

The flag byte has a fixed bit layout. One bit position carries overflow for arithmetic operations and even parity for logical ones. Two further positions mirror result bits 5 and 3. A surrounding core registers the result and flag byte itself and feeds the stored flags back into the flag input. Only the incoming carry bit is ever consumed, and only by the two carry-chained operations.

Top module: `alu8_core`

## Requirements
- R1: The operation select uses these codes: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow. For these codes the result is (a+b), (a+b+Cin), (a-b) and (a-b-Cin), each taken modulo 256, where Cin is bit 0 of the incoming flag byte.
- R2: Codes 4, 5 and 6 select AND, XOR and OR, and the result is the bitwise combination of the two operands.
- R3: Code 7 is compare. The result equals operand a, and the flags are those of (a-b), except for bits 5 and 3.
- R4: Output flag bit 7 (sign) equals bit 7 of the computed value. Bit 6 (zero) is 1 exactly when that value is 0x00. For compare, the computed value is the difference; for every other code it is the result.
- R5: Output flag bits 5 and 3 copy result bits 5 and 3. For compare they copy bits 5 and 3 of operand b instead.
- R6: Flag bit 4 (half carry) behaves as follows. For adds it is the carry out of bit 3. For subtract, subtract-with-borrow and compare it is the borrow into bit 4. It is 1 for AND and 0 for XOR and OR.
- R7: For arithmetic codes, flag bit 2 is overflow. On adds it is set when a and b share a sign bit and the result's sign differs from it. On subtracts and compare it is set when a and b differ in sign and the difference's sign differs from a's sign.
- R8: For logical codes, flag bit 2 is 1 when the result has an even number of one bits.
- R9: Flag bit 1 (subtract) is 1 for codes 2, 3 and 7 and 0 for all other codes.
- R10: Flag bit 0 (carry) behaves as follows. For adds it is the carry out of bit 7. For subtracts and compare it is set when a borrow occurs, that is, when a is less than b plus the borrow in. It is 0 for logical codes.
- R11: The incoming flag byte affects nothing except through its bit 0, and only for codes 1 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation select (codes per R1 to R3) |
| a_i | input | 8 | First operand; passes through on compare |
| b_i | input | 8 | Second operand |
| flags_i | input | 8 | Current flag byte; bit 0 is the carry input |
| result_o | output | 8 | Operation result |
| flags_o | output | 8 | New flag byte |

## Verification
The block holds no state, so every output is due in the same cycle its inputs are applied, after combinational settling only. The bench drives each stimulus just after a rising edge and samples the outputs at the following falling edge, half a period later. Each check therefore sees the settled outputs for that stimulus and never catches a transition. A hand-computed vector table covers the sign, zero, half-carry, overflow and borrow boundaries. After it comes a sweep in which each flag bit is compared on its own against values the bench works out with integer arithmetic.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBC = 3'd3,
    OP_AND = 3'd4,
    OP_XOR = 3'd5,
    OP_OR  = 3'd6,
    OP_CMP = 3'd7
  } alu_op_e;

  // Flag byte, most significant field first.
  typedef struct packed {
    logic sign;
    logic zero;
    logic copy5;
    logic half;
    logic copy3;
    logic par_ovf;
    logic subtr;
    logic carry;
  } flag_byte_t;

  localparam int unsigned FLAG_CARRY_POS = 0;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_XOR = 2'd1,
    LG_OR  = 2'd2
  } logic_fn_e;

endpackage

// File: rtl/alu8_addsub.sv
// Ripple add/subtract core. Subtraction is a + ~b + ~borrow_in, so
// the raw chain carries are inverted to give borrows.
module alu8_addsub #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic              half_o,
  output logic              ovf_o
);
  localparam int unsigned HALF_POS = DATA_W / 2;
  localparam int unsigned MSB      = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   chain;

  assign b_eff    = sub_i ? ~b_i : b_i;
  assign chain[0] = sub_i ? ~cin_i : cin_i;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic prop;
    assign prop         = a_i[i] ^ b_eff[i];
    assign sum_o[i]     = prop ^ chain[i];
    assign chain[i+1]   = (a_i[i] & b_eff[i]) | (chain[i] & prop);
  end

  assign cout_o = sub_i ? ~chain[DATA_W]   : chain[DATA_W];
  assign half_o = sub_i ? ~chain[HALF_POS] : chain[HALF_POS];

  // Sign-comparison overflow rules, separate for each direction.
  always_comb begin
    if (sub_i) begin
      ovf_o = (a_i[MSB] != b_i[MSB]) && (sum_o[MSB] != a_i[MSB]);
    end else begin
      ovf_o = (a_i[MSB] == b_i[MSB]) && (sum_o[MSB] != a_i[MSB]);
    end
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic_fn_e         fn_i,
  output logic [DATA_W-1:0] res_o,
  output logic              even_o
);
  logic [DATA_W:0] par_chain;

  always_comb begin
    unique case (fn_i)
      LG_AND:  res_o = a_i & b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      LG_OR:   res_o = a_i | b_i;
      default: res_o = a_i | b_i;
    endcase
  end

  // Parity accumulates along a chain; seeded with 1 so the end is "even".
  assign par_chain[0] = 1'b1;
  for (genvar i = 0; i < DATA_W; i++) begin : g_par
    assign par_chain[i+1] = par_chain[i] ^ res_o[i];
  end
  assign even_o = par_chain[DATA_W];
endmodule

// File: rtl/alu8_flagpack.sv
module alu8_flagpack
  import alu8_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              arith_i,
  input  logic              cmp_i,
  input  logic              sub_i,
  input  logic              is_and_i,
  input  logic [DATA_W-1:0] value_i,   // value sign/zero are taken from
  input  logic [DATA_W-1:0] copy_src_i, // value bits 5 and 3 are copied from
  input  logic              cout_i,
  input  logic              half_i,
  input  logic              ovf_i,
  input  logic              even_i,
  output flag_byte_t        flags_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic unused_copy_bits;
  assign unused_copy_bits = ^{copy_src_i[DATA_W-1:6], copy_src_i[4], copy_src_i[2:0], cmp_i};

  always_comb begin
    flags_o.sign    = value_i[MSB];
    flags_o.zero    = (value_i == '0);
    flags_o.copy5   = copy_src_i[5];
    flags_o.copy3   = copy_src_i[3];
    flags_o.subtr   = arith_i & sub_i;
    if (arith_i) begin
      flags_o.half    = half_i;
      flags_o.par_ovf = ovf_i;
      flags_o.carry   = cout_i;
    end else begin
      flags_o.half    = is_and_i;
      flags_o.par_ovf = even_i;
      flags_o.carry   = 1'b0;
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [7:0]        flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic [7:0]        flags_o
);
  alu_op_e op;
  logic    is_arith, is_sub, is_cmp, is_and, use_cin, cin;
  logic_fn_e lfn;

  logic [DATA_W-1:0] as_sum, lg_res, flag_value, copy_src;
  logic              as_cout, as_half, as_ovf, lg_even;
  flag_byte_t        fl;

  logic unused_flags_in;
  assign unused_flags_in = ^flags_i[7:1];

  // Decode
  always_comb begin
    op       = alu_op_e'(op_i);
    is_arith = (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) ||
               (op == OP_SBC) || (op == OP_CMP);
    is_sub   = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
    is_cmp   = (op == OP_CMP);
    is_and   = (op == OP_AND);
    use_cin  = (op == OP_ADC) || (op == OP_SBC);
    cin      = use_cin & flags_i[FLAG_CARRY_POS];
    unique case (op)
      OP_AND:  lfn = LG_AND;
      OP_XOR:  lfn = LG_XOR;
      default: lfn = LG_OR;
    endcase
  end

  alu8_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin),
    .sub_i  (is_sub),
    .sum_o  (as_sum),
    .cout_o (as_cout),
    .half_o (as_half),
    .ovf_o  (as_ovf)
  );

  alu8_logic #(.DATA_W(DATA_W)) u_logic (
    .a_i    (a_i),
    .b_i    (b_i),
    .fn_i   (lfn),
    .res_o  (lg_res),
    .even_o (lg_even)
  );

  // Result and flag source selection
  always_comb begin
    flag_value = is_arith ? as_sum : lg_res;
    copy_src   = is_cmp ? b_i : flag_value;
    if (is_cmp) begin
      result_o = a_i;
    end else begin
      result_o = flag_value;
    end
  end

  alu8_flagpack #(.DATA_W(DATA_W)) u_flags (
    .arith_i    (is_arith),
    .cmp_i      (is_cmp),
    .sub_i      (is_sub),
    .is_and_i   (is_and),
    .value_i    (flag_value),
    .copy_src_i (copy_src),
    .cout_i     (as_cout),
    .half_i     (as_half),
    .ovf_i      (as_ovf),
    .even_i     (lg_even),
    .flags_o    (fl)
  );

  assign flags_o = fl;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [7:0]        flags_i,
  input logic [DATA_W-1:0] result_o,
  input logic [7:0]        flags_o
);
  logic is_logic, is_subfam;
  logic unused_chk;
  assign unused_chk = ^{b_i, flags_i};
  assign is_logic  = (op_i == 3'd4) || (op_i == 3'd5) || (op_i == 3'd6);
  assign is_subfam = (op_i == 3'd2) || (op_i == 3'd3) || (op_i == 3'd7);

  always_comb begin
    // R3: compare passes the first operand through
    assert_cmp_keeps_a_R3: assert (op_i != 3'd7 || result_o == a_i)
      else $error("compare result differs from operand a");
    // R9: subtract flag tracks the subtract family
    assert_subflag_R9: assert (flags_o[1] == is_subfam)
      else $error("subtract flag wrong for op %0d", op_i);
    // R10: logical ops leave carry clear
    assert_logic_no_carry_R10: assert (!is_logic || !flags_o[0])
      else $error("carry set by logical op");
    // R8: parity for logical results
    assert_logic_parity_R8: assert (!is_logic || flags_o[2] == ~^result_o)
      else $error("parity flag wrong");
    // R4: zero flag follows result for non-compare ops
    assert_zero_flag_R4: assert (op_i == 3'd7 || flags_o[6] == (result_o == '0))
      else $error("zero flag disagrees with result");
    // R6: AND forces half carry, XOR/OR clear it
    assert_logic_half_R6: assert (!is_logic || flags_o[4] == (op_i == 3'd4))
      else $error("half carry wrong for logical op");
  end
endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
  logic       clk;
  logic       rst_n;
  logic [2:0] op;
  logic [7:0] a, b, fin;
  logic [7:0] res, fout;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  alu8_core u_dut (
    .op_i    (op),
    .a_i     (a),
    .b_i     (b),
    .flags_i (fin),
    .result_o(res),
    .flags_o (fout)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {op, a, b, flags_in, result, flags_out}
  localparam int NV = 17;
  localparam logic [42:0] VECS [0:NV-1] = '{
    {3'd0, 8'h0F, 8'h01, 8'h00, 8'h10, 8'h10},
    {3'd0, 8'h7F, 8'h01, 8'h00, 8'h80, 8'h94},
    {3'd0, 8'hFF, 8'h01, 8'h00, 8'h00, 8'h51},
    {3'd0, 8'h80, 8'h80, 8'h00, 8'h00, 8'h45},
    {3'd0, 8'h10, 8'h20, 8'h01, 8'h30, 8'h20},
    {3'd1, 8'h10, 8'h20, 8'h01, 8'h31, 8'h20},
    {3'd1, 8'h0F, 8'h00, 8'h01, 8'h10, 8'h10},
    {3'd2, 8'h10, 8'h01, 8'h00, 8'h0F, 8'h1A},
    {3'd2, 8'h80, 8'h01, 8'h00, 8'h7F, 8'h3E},
    {3'd3, 8'h00, 8'h00, 8'h01, 8'hFF, 8'hBB},
    {3'd3, 8'h10, 8'h0F, 8'h01, 8'h00, 8'h52},
    {3'd4, 8'hF0, 8'h3C, 8'hFF, 8'h30, 8'h34},
    {3'd5, 8'hAA, 8'h55, 8'hFF, 8'hFF, 8'hAC},
    {3'd6, 8'h00, 8'h01, 8'hFF, 8'h01, 8'h00},
    {3'd6, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h44},
    {3'd7, 8'h20, 8'h28, 8'h00, 8'h20, 8'hBB},
    {3'd7, 8'h42, 8'h42, 8'hFF, 8'h42, 8'h42}
  };

  function automatic string op_tag(input logic [2:0] o);
    if (o <= 3'd3) return "R1";
    if (o == 3'd7) return "R3";
    return "R2";
  endfunction

  task automatic chk8(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h (op=%0d a=%02h b=%02h fin=%02h)",
               tag, got, exp, op, a, b, fin);
    end
  endtask

  task automatic drive(input logic [2:0] o, input logic [7:0] x, input logic [7:0] y,
                       input logic [7:0] f);
    @(posedge clk);
    op = o; a = x; b = y; fin = f;
    @(negedge clk);
  endtask

  // Independent reference built from the requirement text.
  function automatic logic [15:0] model(input logic [2:0] o, input logic [7:0] x,
                                        input logic [7:0] y, input logic [7:0] f);
    int ai, bi, ci, full, lo;
    logic [7:0] r, v, fl, src;
    logic hc, ov, cy, sgn_a, sgn_b;
    ai = x; bi = y; ci = (o == 3'd1 || o == 3'd3) ? int'(f[0]) : 0;
    sgn_a = x[7]; sgn_b = y[7];
    fl = 8'h00; hc = 0; ov = 0; cy = 0;
    if (o <= 3'd1) begin
      full = ai + bi + ci; v = full[7:0];
      lo = (ai % 16) + (bi % 16) + ci; hc = (lo > 15); cy = (full > 255);
      ov = (sgn_a == sgn_b) && (v[7] != sgn_a);
      r = v;
    end else if (o == 3'd2 || o == 3'd3 || o == 3'd7) begin
      full = ai - bi - ci; v = full[7:0];
      lo = (ai % 16) - (bi % 16) - ci; hc = (lo < 0); cy = (full < 0);
      ov = (sgn_a != sgn_b) && (v[7] != sgn_a);
      fl[1] = 1'b1;
      r = (o == 3'd7) ? x : v;
    end else begin
      if (o == 3'd4) v = x & y; else if (o == 3'd5) v = x ^ y; else v = x | y;
      r = v; hc = (o == 3'd4);
      ov = ($countones(v) % 2) == 0;
    end
    src = (o == 3'd7) ? y : v;
    fl[7] = v[7]; fl[6] = (v == 8'h00); fl[5] = src[5]; fl[3] = src[3];
    fl[4] = hc; fl[2] = ov; fl[0] = cy;
    return {r, fl};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] m;
    op = 3'd0; a = 8'h00; b = 8'h00; fin = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Idle state: add of zeros gives zero result with only the zero flag (R4)
    chk8("R1 idle result", res, 8'h00);
    chk8("R4 idle flags", fout, 8'h40);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i][42:40], VECS[i][39:32], VECS[i][31:24], VECS[i][23:16]);
      chk8(op_tag(VECS[i][42:40]), res, VECS[i][15:8]);
      chk8("flags R4 R5 R6 R7 R8 R9 R10", fout, VECS[i][7:0]);
    end

    // R11: carry-in ignored by plain add and subtract
    drive(3'd0, 8'h3C, 8'h41, 8'hFF);
    chk8("R11 add ignores carry in", res, 8'h7D);
    drive(3'd2, 8'h3C, 8'h41, 8'hFF);
    chk8("R11 sub ignores carry in", res, 8'hFB);
    // R11: compare ignores incoming carry too
    drive(3'd7, 8'h05, 8'h05, 8'h01);
    chk8("R11 cmp ignores carry in", fout, 8'h42);
    // R7: subtract overflow from negative minus positive
    drive(3'd2, 8'h80, 8'h7F, 8'h00);
    chk8("R7 sub overflow result", res, 8'h01);
    chk8("R7 sub overflow flags", fout & 8'h05, 8'h04);
    // R10: borrow from subtract-with-borrow at equal operands
    drive(3'd3, 8'h55, 8'h55, 8'h01);
    chk8("R10 sbc borrow", fout & 8'h01, 8'h01);
    // R5: compare copies bits 5 and 3 of b, not of a
    drive(3'd7, 8'hD7, 8'h00, 8'h00);
    chk8("R5 cmp copies from b", fout & 8'h28, 8'h00);

    // Sweep of all codes against the integer reference
    for (int o = 0; o < 8; o++) begin
      for (int x = 0; x < 256; x += 17) begin
        for (int y = 0; y < 256; y += 23) begin
          drive(3'(o), 8'(x), 8'(y), 8'(x ^ y ^ o));
          m = model(3'(o), 8'(x), 8'(y), 8'(x ^ y ^ o));
          chk8(op_tag(3'(o)), res, m[15:8]);
          chk8("R4 sign zero", fout & 8'hC0, m[7:0] & 8'hC0);
          chk8("R5 copies", fout & 8'h28, m[7:0] & 8'h28);
          chk8("R6 half", fout & 8'h10, m[7:0] & 8'h10);
          chk8((o >= 4 && o <= 6) ? "R8 parity" : "R7 overflow", fout & 8'h04, m[7:0] & 8'h04);
          chk8("R9 subtract flag", fout & 8'h02, m[7:0] & 8'h02);
          chk8("R10 carry", fout & 8'h01, m[7:0] & 8'h01);
        end
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule